// File: doc/BRIEF.md
# Dual-Bank Byte-Lane Memory Bridge

This block connects a 16-bit processor-side request port to a memory built from two 8-bit banks that together hold a 1 MB byte-addressable space. Even byte addresses live in the low bank, which is wired to data lanes 7..0. Odd byte addresses live in the high bank, which is wired to lanes 15..8. Both banks share one in-bank word address. Each bank has its own active-low select: the low bank is selected when the address-bit-0 line is 0, and the high bank is selected when the high-lane enable is 0.

A request gives a 20-bit byte address, a byte or word size, and a read or write strobe. The request is taken only while `idle` is high. Byte accesses and word accesses at even addresses each use one bus cycle. A word access at an odd address is split into two byte cycles, and the bridge reassembles the halves in the correct order. `done` pulses for one clock when an access finishes. On a read, `rd_data` holds the assembled value from the same cycle onward.

Top module: `bank_lane_bridge`

## Requirements
- R1: While idle, including straight after reset, `mem_a0` and `mem_bhe_n` are both 1, so neither bank is selected. `mem_rd` and `mem_wr` are 0, `idle` is 1 and `done` is 0.
- R2: During every bus cycle, `mem_addr` carries bits 19..1 of the byte address being accessed in that cycle.
- R3: A byte access at an even address drives `mem_a0`=0 and `mem_bhe_n`=1. A read returns lanes 7..0 in `rd_data[7:0]`, with `rd_data[15:8]`=0.
- R4: A byte access at an odd address drives `mem_a0`=1 and `mem_bhe_n`=0. A read returns lanes 15..8 shifted down into `rd_data[7:0]`, with `rd_data[15:8]`=0.
- R5: A word access at an even address drives `mem_a0`=0 and `mem_bhe_n`=0 for exactly one bus cycle. The even byte is on lanes 7..0 and the odd byte on lanes 15..8. `done` is high in the second cycle after the accepting edge.
- R6: A word access at an odd address X uses two bus cycles. The first is a high-bank byte cycle at X, whose byte is bits 7..0 of the word. The second is a low-bank byte cycle at X+1, whose byte is bits 15..8 of the word. `done` is high in the third cycle after the accepting edge.
- R7: When the split access starts at 0xFFFFF, the second cycle's byte address wraps to 0x00000, so `mem_addr`=0 and `mem_a0`=0.
- R8: `done` is high for exactly one clock per access, in the cycle that follows the final bus cycle.
- R9: A strobe that arrives while the bridge is not idle is ignored. It causes no extra bus cycle and changes no memory content.
- R10: A byte write drives the byte, taken from `req_wdata[7:0]`, onto both lanes, and only the selected bank stores it. An aligned word write drives `req_wdata` unchanged. A split write sends `req_wdata[7:0]` in the first cycle and `req_wdata[15:8]` in the second.
- R11: If `req_rd` and `req_wr` are both asserted, the access is a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_rd | input | 1 | Read request strobe |
| req_wr | input | 1 | Write request strobe |
| req_addr | input | 20 | Byte address of the request |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_wdata | input | 16 | Write data; a byte write uses bits 7..0 |
| idle | output | 1 | High when a request can be accepted |
| done | output | 1 | One-clock pulse when an access completes |
| rd_data | output | 16 | Assembled read result |
| mem_addr | output | 19 | Shared in-bank word address |
| mem_a0 | output | 1 | Address bit 0; low selects the even bank |
| mem_bhe_n | output | 1 | Active-low high-lane enable; low selects the odd bank |
| mem_rd | output | 1 | Bus read strobe |
| mem_wr | output | 1 | Bus write strobe |
| mem_wdata | output | 16 | Data lanes toward the banks |
| mem_rdata | input | 16 | Data lanes from the banks |

## Verification
A request presented before edge E0 is accepted at E0. The first bus cycle is then visible between E0 and E1. For a single-cycle access, `done` and `rd_data` are due between E1 and E2. For a split access, the second bus cycle is visible between E1 and E2, and the results are due between E2 and E3. The bench drives and samples on falling edges only. It records lane enables, the address and the write lanes once per falling edge, and takes the latency as the falling edge at which `done` is first seen, counted from acceptance. It then checks one further falling edge to confirm that the pulse has ended. The bank model returns 0xEE on an unselected lane, so a result that takes its bytes from the wrong lane shows up as a wrong value.

// File: rtl/lane_pkg.sv
// Shared types for the dual-bank bridge.
// Assumes: at most two bus cycles per access.
package lane_pkg;
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_FIRST  = 2'd1,
        PH_SECOND = 2'd2
    } phase_t;
endpackage

// File: rtl/lane_seq.sv
// Access sequencer: latches one request while idle and walks through one
// or two bus cycles. It also produces the byte address of the current cycle.
// Assumes: the request strobes are only looked at in PH_IDLE.
module lane_seq
    import lane_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_rd,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_word,
    input  logic [DATA_W-1:0] req_wdata,
    output phase_t            phase,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              op_word,
    output logic              op_wr,
    output logic              last,
    output logic [DATA_W-1:0] op_wdata
);
    logic [ADDR_W-1:0] base_q;
    logic              split;

    // A word at an odd address needs two cycles.
    assign split    = op_word && base_q[0];
    // In the second cycle the address is X+1, which wraps naturally at ADDR_W bits.
    assign cur_addr = (phase == PH_SECOND) ? base_q + ADDR_W'(1) : base_q;
    assign last     = (phase == PH_SECOND) || ((phase == PH_FIRST) && !split);

    // Phase register and request capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            base_q   <= '0;
            op_word  <= 1'b0;
            op_wr    <= 1'b0;
            op_wdata <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (req_rd || req_wr) begin
                        phase    <= PH_FIRST;
                        base_q   <= req_addr;
                        op_word  <= req_word;
                        op_wr    <= req_wr;
                        op_wdata <= req_wdata;
                    end
                end
                PH_FIRST: phase <= split ? PH_SECOND : PH_IDLE;
                default:  phase <= PH_IDLE;
            endcase
        end
    end

    // R6 / R7: the second cycle addresses the next byte, rolling over at the top.
    p_split_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FIRST && split) |=>
        (phase == PH_SECOND && cur_addr == $past(cur_addr) + ADDR_W'(1)));

    p_aligned_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FIRST && !split) |=> (phase == PH_IDLE));

    p_busy_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE) |=> ($stable(base_q) && $stable(op_wr)));
endmodule

// File: rtl/lane_steer.sv
// Lane steering: turns the current phase and address into the bank selects,
// the shared address, the strobes and the write lanes. Purely combinational.
// Assumes: cur_addr is even in PH_SECOND.
module lane_steer
    import lane_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int BYTE_W = 8
) (
    input  phase_t              phase,
    input  logic [ADDR_W-1:0]   cur_addr,
    input  logic                op_word,
    input  logic                op_wr,
    input  logic [2*BYTE_W-1:0] op_wdata,
    output logic [ADDR_W-2:0]   mem_addr,
    output logic                mem_a0,
    output logic                mem_bhe_n,
    output logic                mem_rd,
    output logic                mem_wr,
    output logic [2*BYTE_W-1:0] mem_wdata
);
    logic              active;
    logic              both;
    logic [BYTE_W-1:0] byte_src;

    // Bank select, address and write lane decode.
    always_comb begin
        active    = (phase != PH_IDLE);
        both      = active && op_word && (phase == PH_FIRST) && !cur_addr[0];
        mem_addr  = cur_addr[ADDR_W-1:1];
        if (!active) begin
            mem_a0    = 1'b1;
            mem_bhe_n = 1'b1;
        end else if (both) begin
            mem_a0    = 1'b0;
            mem_bhe_n = 1'b0;
        end else begin
            mem_a0    = cur_addr[0];
            mem_bhe_n = !cur_addr[0];
        end
        byte_src  = (phase == PH_SECOND) ? op_wdata[2*BYTE_W-1:BYTE_W]
                                         : op_wdata[BYTE_W-1:0];
        mem_wdata = both ? op_wdata : {2{byte_src}};
        mem_rd    = active && !op_wr;
        mem_wr    = active && op_wr;
    end
endmodule

// File: rtl/lane_gather.sv
// Read assembly: moves the selected lane down to the low byte, holds the
// first half of a split read, and raises done after the final cycle.
// Assumes: mem_rdata is valid during the cycle in which the strobe is high.
module lane_gather
    import lane_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  phase_t              phase,
    input  logic                last,
    input  logic                op_wr,
    input  logic                mem_a0,
    input  logic                mem_bhe_n,
    input  logic [2*BYTE_W-1:0] mem_rdata,
    output logic                done,
    output logic [2*BYTE_W-1:0] rd_data
);
    logic              hi_only;
    logic [BYTE_W-1:0] got_byte;
    logic [BYTE_W-1:0] hold_q;

    // Pick the lane of a single-bank cycle.
    assign hi_only  = mem_a0 && !mem_bhe_n;
    assign got_byte = hi_only ? mem_rdata[2*BYTE_W-1:BYTE_W] : mem_rdata[BYTE_W-1:0];

    // Completion pulse and result register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done    <= 1'b0;
            rd_data <= '0;
            hold_q  <= '0;
        end else begin
            done <= (phase != PH_IDLE) && last;
            if (phase != PH_IDLE && !op_wr) begin
                if (!last)
                    hold_q <= got_byte;
                else if (!mem_a0 && !mem_bhe_n)
                    rd_data <= mem_rdata;
                else if (phase == PH_SECOND)
                    rd_data <= {got_byte, hold_q};
                else
                    rd_data <= {{BYTE_W{1'b0}}, got_byte};
            end
        end
    end

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_after_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(phase) != PH_IDLE));
endmodule

// File: rtl/bank_lane_bridge.sv
// Top of the dual-bank bridge: sequencer, lane steering and read assembly.
// Assumes: the banks give read data in the same cycle and store on the clock edge.
module bank_lane_bridge
    import lane_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_rd,
    input  logic                req_wr,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic                req_word,
    input  logic [2*BYTE_W-1:0] req_wdata,
    output logic                idle,
    output logic                done,
    output logic [2*BYTE_W-1:0] rd_data,
    output logic [ADDR_W-2:0]   mem_addr,
    output logic                mem_a0,
    output logic                mem_bhe_n,
    output logic                mem_rd,
    output logic                mem_wr,
    output logic [2*BYTE_W-1:0] mem_wdata,
    input  logic [2*BYTE_W-1:0] mem_rdata
);
    localparam int DATA_W = 2 * BYTE_W;

    phase_t            phase;
    logic [ADDR_W-1:0] cur_addr;
    logic              op_word;
    logic              op_wr;
    logic              last;
    logic [DATA_W-1:0] op_wdata;

    assign idle = (phase == PH_IDLE);

    lane_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .req_rd(req_rd), .req_wr(req_wr),
        .req_addr(req_addr), .req_word(req_word), .req_wdata(req_wdata),
        .phase(phase), .cur_addr(cur_addr), .op_word(op_word), .op_wr(op_wr),
        .last(last), .op_wdata(op_wdata)
    );

    lane_steer #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_steer (
        .phase(phase), .cur_addr(cur_addr), .op_word(op_word), .op_wr(op_wr),
        .op_wdata(op_wdata), .mem_addr(mem_addr), .mem_a0(mem_a0),
        .mem_bhe_n(mem_bhe_n), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata)
    );

    lane_gather #(.BYTE_W(BYTE_W)) u_gather (
        .clk(clk), .rst_n(rst_n), .phase(phase), .last(last), .op_wr(op_wr),
        .mem_a0(mem_a0), .mem_bhe_n(mem_bhe_n), .mem_rdata(mem_rdata),
        .done(done), .rd_data(rd_data)
    );

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (mem_a0 && mem_bhe_n && !mem_rd && !mem_wr));

    p_lane_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> !(mem_a0 && mem_bhe_n));

    p_byte_mirror_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && (mem_a0 || mem_bhe_n)) |->
        (mem_wdata[DATA_W-1:BYTE_W] == mem_wdata[BYTE_W-1:0]));
endmodule

// File: tb/test_bank_lane_bridge.sv
`timescale 1ns/1ps
module test_bank_lane_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_rd = 1'b0, req_wr = 1'b0, req_word = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        idle, done, mem_a0, mem_bhe_n, mem_rd, mem_wr;
    logic [15:0] rd_data, mem_wdata, mem_rdata;
    logic [18:0] mem_addr;

    int checks = 0;
    int errors = 0;

    logic [7:0] lo_bank [256];
    logic [7:0] hi_bank [256];

    // Recorded bus cycles of the last access.
    int          b_n, lat;
    logic        b_a0 [2];
    logic        b_bhe [2];
    logic        b_wr [2];
    logic [18:0] b_addr [2];
    logic [15:0] b_wd [2];
    logic [15:0] res;
    logic        idle_ok, pulse_after;

    always #2.5 clk = ~clk;

    bank_lane_bridge i_bank_lane_bridge (
        .clk(clk), .rst_n(rst_n), .req_rd(req_rd), .req_wr(req_wr),
        .req_addr(req_addr), .req_word(req_word), .req_wdata(req_wdata),
        .idle(idle), .done(done), .rd_data(rd_data), .mem_addr(mem_addr),
        .mem_a0(mem_a0), .mem_bhe_n(mem_bhe_n), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Bank model: same-cycle read, write on the edge, 0xEE on an unselected lane.
    always @(posedge clk) begin
        if (mem_wr) begin
            if (!mem_a0)    lo_bank[mem_addr[7:0]] <= mem_wdata[7:0];
            if (!mem_bhe_n) hi_bank[mem_addr[7:0]] <= mem_wdata[15:8];
        end
    end
    assign mem_rdata = {(!mem_bhe_n ? hi_bank[mem_addr[7:0]] : 8'hEE),
                        (!mem_a0    ? lo_bank[mem_addr[7:0]] : 8'hEE)};

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Runs one access; with hold set, a write strobe stays up while busy.
    task automatic run(input logic wr, input logic rd, input logic [19:0] a,
                       input logic word, input logic [15:0] wd, input logic hold);
        @(negedge clk);
        req_wr = wr; req_rd = rd; req_addr = a; req_word = word; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        if (hold) begin
            req_rd = 1'b0; req_wr = 1'b1; req_addr = 20'h00020;
            req_word = 1'b1; req_wdata = 16'hFFFF;
        end else begin
            req_rd = 1'b0; req_wr = 1'b0;
        end
        b_n = 0; lat = 0;
        for (int k = 1; k <= 6; k++) begin
            if (k > 1) @(negedge clk);
            if (done) begin
                lat = k;
                res = rd_data;
                idle_ok = mem_a0 && mem_bhe_n && !mem_rd && !mem_wr && idle;
                break;
            end
            if (mem_rd || mem_wr) begin
                if (b_n < 2) begin
                    b_a0[b_n] = mem_a0; b_bhe[b_n] = mem_bhe_n; b_wr[b_n] = mem_wr;
                    b_addr[b_n] = mem_addr; b_wd[b_n] = mem_wdata;
                end
                b_n++;
            end
        end
        req_rd = 1'b0; req_wr = 1'b0;
        @(negedge clk);
        pulse_after = done;
    endtask

    task automatic t_reset;
        chk("R1 idle after reset", idle, 1);
        chk("R1 done after reset", done, 0);
        chk("R1 selects after reset", {mem_a0, mem_bhe_n}, 2'b11);
        chk("R1 strobes after reset", {mem_rd, mem_wr}, 2'b00);
    endtask

    task automatic t_word_aligned;
        run(1, 0, 20'h00010, 1, 16'hBEEF, 0);
        chk("R5 bus cycles", b_n, 1);
        chk("R5 selects", {b_a0[0], b_bhe[0]}, 2'b00);
        chk("R2 bank address", b_addr[0], 19'h00008);
        chk("R10 word lanes", b_wd[0], 16'hBEEF);
        chk("R5 latency", lat, 2);
        chk("R1 idle at done", idle_ok, 1);
        chk("R8 pulse ends", pulse_after, 0);
        run(0, 1, 20'h00010, 1, 16'h0, 0);
        chk("R5 read value", res, 16'hBEEF);
        chk("R5 read latency", lat, 2);
    endtask

    task automatic t_bytes;
        run(1, 0, 20'h00020, 0, 16'h7711, 0);
        chk("R3 write selects", {b_a0[0], b_bhe[0]}, 2'b01);
        chk("R10 even mirror", b_wd[0], 16'h1111);
        run(1, 0, 20'h00021, 0, 16'h6622, 0);
        chk("R4 write selects", {b_a0[0], b_bhe[0]}, 2'b10);
        chk("R10 odd mirror", b_wd[0], 16'h2222);
        chk("R2 odd bank address", b_addr[0], 19'h00010);
        run(0, 1, 20'h00020, 1, 16'h0, 0);
        chk("R10 only selected bank stored", res, 16'h2211);
        run(0, 1, 20'h00020, 0, 16'h0, 0);
        chk("R3 even byte read", res, 16'h0011);
        chk("R3 byte latency", lat, 2);
        run(0, 1, 20'h00021, 0, 16'h0, 0);
        chk("R4 odd byte read", res, 16'h0022);
        chk("R4 read selects", {b_a0[0], b_bhe[0]}, 2'b10);
    endtask

    task automatic t_split;
        run(1, 0, 20'h00031, 1, 16'hC3A7, 0);
        chk("R6 bus cycles", b_n, 2);
        chk("R6 first selects", {b_a0[0], b_bhe[0]}, 2'b10);
        chk("R6 first address", b_addr[0], 19'h00018);
        chk("R10 first lanes", b_wd[0], 16'hA7A7);
        chk("R6 second selects", {b_a0[1], b_bhe[1]}, 2'b01);
        chk("R6 second address", b_addr[1], 19'h00019);
        chk("R10 second lanes", b_wd[1], 16'hC3C3);
        chk("R6 latency", lat, 3);
        chk("R8 split pulse ends", pulse_after, 0);
        run(0, 1, 20'h00031, 0, 16'h0, 0);
        chk("R6 low half stored odd", res, 16'h00A7);
        run(0, 1, 20'h00032, 0, 16'h0, 0);
        chk("R6 high half stored even", res, 16'h00C3);
        run(0, 1, 20'h00031, 1, 16'h0, 0);
        chk("R6 split read", res, 16'hC3A7);
        chk("R6 split read latency", lat, 3);
    endtask

    task automatic t_wrap;
        run(1, 0, 20'hFFFFF, 1, 16'h5A6B, 0);
        chk("R7 first address", b_addr[0], 19'h7FFFF);
        chk("R7 second address", b_addr[1], 19'h00000);
        chk("R7 second a0", b_a0[1], 0);
        run(0, 1, 20'hFFFFF, 1, 16'h0, 0);
        chk("R7 wrapped read", res, 16'h5A6B);
        run(0, 1, 20'h00000, 0, 16'h0, 0);
        chk("R7 byte at zero", res, 16'h005A);
    endtask

    task automatic t_busy;
        run(0, 1, 20'h00031, 1, 16'h0, 1);
        chk("R9 bus cycles while busy", b_n, 2);
        chk("R9 no write while busy", b_wr[0] | b_wr[1], 0);
        chk("R9 result kept", res, 16'hC3A7);
        chk("R9 idle after busy", idle, 1);
        run(0, 1, 20'h00020, 1, 16'h0, 0);
        chk("R9 memory untouched", res, 16'h2211);
    endtask

    task automatic t_both;
        run(1, 1, 20'h00040, 1, 16'h1357, 0);
        chk("R11 write strobe", b_wr[0], 1);
        run(0, 1, 20'h00040, 1, 16'h0, 0);
        chk("R11 stored", res, 16'h1357);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_word_aligned();
        t_bytes();
        t_split();
        t_wrap();
        t_busy();
        t_both();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule